// File: doc/BRIEF.md
# Change-of-state input interrupt controller

This block watches 48 digital inputs and raises an interrupt when any of them changes. The inputs are split into six groups of eight. A small byte-wide register bus reads each group at its own address. Each input is first brought into the clock domain through a synchronizer. A toggle in either direction on any bit of an enabled group then latches a per-group flag, and the level interrupt output stays high while any flag is set.

Software uses one control address for two jobs. A write to it sets the per-group enable mask. A read from it returns the group flags together with an active-low pending bit, and that read also clears the flags. Masking of individual bits is left to software: the handler reads the flags, then reads the flagged groups to find which bits changed.

Top module: `cos_input_ctrl`

## Requirements
- R1: Group g (bits g*8+7..g*8 of `din`) is read at byte offset g for g = 0..2 and at offset g+1 for g = 3..5. Bit n of the byte is input g*8+n. Reads return the value after a two-flop synchronizer, so a change driven before clock edge k is visible in a read after edge k+1 and not before.
- R2: A read at offset 3 returns 8'h00.
- R3: A write to offset 7 loads `bus_wdata[5:0]` as the enable mask, where bit k enables group k. Writes to every other offset leave the mask unchanged.
- R4: After reset the mask and all flags are 0, `irq` is 0, and a read at offset 7 returns 8'h40.
- R5: A rising or falling edge on any bit of an enabled group sets flag k and drives `irq` high. This happens at the third clock edge after the input change.
- R6: An edge in a disabled group never sets that group's flag.
- R7: A read at offset 7 returns the flags in bits 5..0, the inverse of `irq` in bit 6 and 0 in bit 7. At the end of that read cycle all flags clear and `irq` falls.
- R8: An edge that is latched in the same cycle as a clearing read is kept and reported by the next read.
- R9: Clearing an enable bit also clears that group's pending flag.
- R10: `irq` is a level signal. It stays high with no further edges until the flags are cleared by a read or by disabling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 48 | Monitored inputs, asynchronous to `clk` |
| bus_addr | input | 3 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high, 0 otherwise |
| irq | output | 1 | Level interrupt, high while any group flag is set |

## Verification
A wrong enable mask or a stuck flag shows up at the ports within one access. If a group is enabled that should not be, or a flag survives a clearing read, `irq` is high at the following sample and the next offset-7 read shows a nonzero low field. A synchronizer with the wrong depth moves both the group read and the flag by one cycle, so the bench samples reads exactly one edge before and one edge after the expected latency. The interaction between a clearing read and a new edge in the same cycle can only be seen by placing the read on the cycle in which the edge is latched. That read must show the old flags, and the read after it must show only the new group.

// File: rtl/cos_pkg.sv
package cos_pkg;
   localparam int         BUS_AW     = 3;
   localparam int         BUS_DW     = 8;
   localparam int         MAX_GROUPS = 6;
   localparam int         PEND_BIT   = 6;
   localparam logic [2:0] CTRL_OFF   = 3'd7;
   localparam logic [2:0] GAP_OFF    = 3'd3;

   // Group data skips offset 3; offset 7 is control/status.
   function automatic logic [2:0] grp_off(input int g);
      return (g < 3) ? 3'(g) : 3'(g + 1);
   endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_sync,
   output logic [WIDTH-1:0] d_edge
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cos_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cos_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg_q [STAGES];
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
         prev_q <= '0;
      end else begin
         stg_q[0] <= d_in;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
         prev_q <= stg_q[STAGES-1];
      end
   end

   assign d_sync = stg_q[STAGES-1];
   assign d_edge = d_sync ^ prev_q;
endmodule

// File: rtl/cos_status.sv
module cos_status #(
   parameter int GROUPS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GROUPS-1:0] grp_edge,
   input  logic              en_we,
   input  logic [GROUPS-1:0] en_wdata,
   input  logic              rd_clr,
   output logic [GROUPS-1:0] en_q,
   output logic [GROUPS-1:0] status_q
);
   logic [GROUPS-1:0] en_d;
   logic [GROUPS-1:0] status_d;

   always_comb begin
      en_d     = en_we ? en_wdata : en_q;
      status_d = ((rd_clr ? '0 : status_q) | (grp_edge & en_q)) & en_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         status_q <= '0;
      end else begin
         en_q     <= en_d;
         status_q <= status_d;
      end
   end

   assert_en_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en_we |=> (en_q == $past(en_wdata)));
   assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !en_we |=> $stable(en_q));
   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !en_we && ((grp_edge & en_q) == '0)) |=> (status_q == '0));

   for (genvar g = 0; g < GROUPS; g++) begin : g_chk
      assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !en_q[g] |=> !status_q[g]);
      assert_edge_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_edge[g] && en_q[g] && !(en_we && !en_wdata[g])) |=> status_q[g]);
      assert_keep_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_clr && grp_edge[g] && en_q[g] && !en_we) |=> status_q[g]);
      assert_drop_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (en_we && !en_wdata[g]) |=> !status_q[g]);
      assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (status_q[g] && !rd_clr && !(en_we && !en_wdata[g])) |=> status_q[g]);
   end
endmodule

// File: rtl/cos_rd_mux.sv
module cos_rd_mux
   import cos_pkg::*;
#(
   parameter int GROUPS    = 6,
   parameter int GROUP_W   = 8,
   parameter bit GATE_IDLE = 1'b1
) (
   input  logic [BUS_AW-1:0]         addr,
   input  logic                      rd,
   input  logic [GROUPS*GROUP_W-1:0] grp_data,
   input  logic [GROUPS-1:0]         status,
   input  logic                      irq,
   output logic [BUS_DW-1:0]         rdata
);
   logic [BUS_DW-1:0] sel;

   always_comb begin
      sel = '0;
      if (addr == CTRL_OFF) begin
         sel[GROUPS-1:0] = status;
         sel[PEND_BIT]   = ~irq;
      end
      for (int g = 0; g < GROUPS; g++) begin
         if (addr == grp_off(g)) sel[GROUP_W-1:0] = grp_data[g*GROUP_W +: GROUP_W];
      end
   end

   if (GATE_IDLE) begin : g_gated
      assign rdata = rd ? sel : '0;
   end else begin : g_open
      assign rdata = sel;
   end
endmodule

// File: rtl/cos_input_ctrl.sv
module cos_input_ctrl
   import cos_pkg::*;
#(
   parameter int GROUPS       = 6,
   parameter int GROUP_W      = 8,
   parameter int SYNC_STAGES  = 2,
   parameter bit GATE_IDLE_RD = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [GROUPS*GROUP_W-1:0] din,
   input  logic [2:0]                bus_addr,
   input  logic                      bus_rd,
   input  logic                      bus_wr,
   input  logic [7:0]                bus_wdata,
   output logic [7:0]                bus_rdata,
   output logic                      irq
);
   localparam int NIN = GROUPS * GROUP_W;

   if (GROUPS < 1 || GROUPS > MAX_GROUPS) begin : g_bad_groups
      $error("cos_input_ctrl: GROUPS must be 1..6");
   end
   if (GROUP_W < 1 || GROUP_W > BUS_DW) begin : g_bad_gw
      $error("cos_input_ctrl: GROUP_W must be 1..8");
   end

   logic [NIN-1:0]    din_sync;
   logic [NIN-1:0]    din_edge;
   logic [GROUPS-1:0] grp_edge;
   logic [GROUPS-1:0] en_q;
   logic [GROUPS-1:0] status_q;
   logic              ctrl_sel;
   logic              unused_wbits;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      cos_sync #(.WIDTH(GROUP_W), .STAGES(SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .d_in   (din[g*GROUP_W +: GROUP_W]),
         .d_sync (din_sync[g*GROUP_W +: GROUP_W]),
         .d_edge (din_edge[g*GROUP_W +: GROUP_W])
      );
      assign grp_edge[g] = |din_edge[g*GROUP_W +: GROUP_W];
   end

   assign ctrl_sel     = (bus_addr == CTRL_OFF);
   assign unused_wbits = ^bus_wdata[BUS_DW-1:GROUPS];

   cos_status #(.GROUPS(GROUPS)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .grp_edge (grp_edge),
      .en_we    (bus_wr && ctrl_sel),
      .en_wdata (bus_wdata[GROUPS-1:0]),
      .rd_clr   (bus_rd && ctrl_sel),
      .en_q     (en_q),
      .status_q (status_q)
   );

   assign irq = |status_q;

   cos_rd_mux #(.GROUPS(GROUPS), .GROUP_W(GROUP_W), .GATE_IDLE(GATE_IDLE_RD)) u_mux (
      .addr     (bus_addr),
      .rd       (bus_rd),
      .grp_data (din_sync),
      .status   (status_q),
      .irq      (irq),
      .rdata    (bus_rdata)
   );

   assert_gap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == GAP_OFF) |-> (bus_rdata == '0));
   assert_pend_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && ctrl_sel) |-> (bus_rdata[PEND_BIT] == !irq && !bus_rdata[7]));
   assert_irq_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && ctrl_sel && !bus_wr && ((grp_edge & en_q) == '0)) |=> !irq);
endmodule

// File: tb/sim_cos_input_ctrl.sv
`timescale 1ns/1ps
module sim_cos_input_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [47:0] din = '0;
   logic [2:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // 50 MHz
   always #10 clk = ~clk;

   cos_input_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .din(din), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   localparam int OFF [6] = '{0, 1, 2, 4, 5, 6};

   // {enable mask, new din, expected group flags}
   localparam logic [59:0] VEC [6] = '{
      {6'h3F, 48'h000000000001, 6'h01},
      {6'h3F, 48'h800000000001, 6'h20},
      {6'h05, 48'h800000FF0000, 6'h05},
      {6'h38, 48'h00AA55FF0000, 6'h38},
      {6'h03, 48'h00AA55FFFF0F, 6'h03},
      {6'h3F, 48'h00AA55FFFF0F, 6'h00}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      bus_rd   = 1'b1;
      #5;
      d = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] v);
      bus_addr  = a;
      bus_wdata = v;
      bus_wr    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      finish_run();
   end

   initial begin
      logic [7:0] d;
      cycles(3);
      rst_n = 1'b1;
      cycles(2);

      // R4 reset state
      chk("R4 irq after reset", {7'd0, irq}, 8'h00);
      rd(3'd7, d); chk("R4 status after reset", d, 8'h40);
      // R2 gap offset
      rd(3'd3, d); chk("R2 gap read", d, 8'h00);

      // R3 writes to other offsets ignored; R6 edge in disabled group
      wr(3'd0, 8'h3F);
      wr(3'd3, 8'h3F);
      din[0] = 1'b1;
      cycles(4);
      chk("R3 stray write leaves mask 0", {7'd0, irq}, 8'h00);
      rd(3'd7, d); chk("R6 disabled edge not flagged", d, 8'h40);
      din[0] = 1'b0;
      cycles(4);

      // table walk: R5 both edge directions, R1 group mapping, R6 partial masks
      foreach (VEC[i]) begin
         logic [5:0]  en_v;
         logic [47:0] din_v;
         logic [5:0]  exp_v;
         {en_v, din_v, exp_v} = VEC[i];
         wr(3'd7, {2'b00, en_v});
         rd(3'd7, d);
         din = din_v;
         cycles(4);
         chk("R5 irq level from table", {7'd0, irq}, {7'd0, exp_v != 6'h00});
         rd(3'd7, d);
         chk("R5 R6 R7 status from table", d, {1'b0, exp_v == 6'h00, exp_v});
         for (int g = 0; g < 6; g++) begin
            rd(3'(OFF[g]), d);
            chk("R1 group byte", d, din_v[g*8 +: 8]);
         end
      end

      // R1 synchronizer latency; din now 00AA55FFFF0F, mask 3F
      din[15:8] = 8'h3C;
      rd(3'd1, d);
      rd(3'd1, d); chk("R1 one edge after change still old", d, 8'hFF);
      rd(3'd1, d); chk("R1 two edges after change new", d, 8'h3C);
      cycles(2);
      chk("R5 irq after group1 edge", {7'd0, irq}, 8'h01);
      cycles(10);
      chk("R10 irq holds as level", {7'd0, irq}, 8'h01);

      // R8 edge latched on the clearing read cycle
      din[23:16] = 8'h00;
      cycles(2);
      rd(3'd7, d); chk("R7 read shows old flags", d, 8'h02);
      chk("R8 irq kept by coincident edge", {7'd0, irq}, 8'h01);
      rd(3'd7, d); chk("R8 coincident edge reported", d, 8'h04);
      chk("R7 irq cleared by read", {7'd0, irq}, 8'h00);
      rd(3'd7, d); chk("R7 status empty after read", d, 8'h40);

      // R9 disabling drops pending flag
      din[7:0]   = ~din[7:0];
      din[31:24] = ~din[31:24];
      cycles(4);
      chk("R9 irq before disable", {7'd0, irq}, 8'h01);
      wr(3'd7, 8'h08);
      rd(3'd7, d); chk("R9 only enabled flag left", d, 8'h08);
      din[31:24] = ~din[31:24];
      cycles(4);
      wr(3'd7, 8'h00);
      chk("R9 irq after full disable", {7'd0, irq}, 8'h00);
      rd(3'd7, d); chk("R9 status after full disable", d, 8'h40);

      // R6 edge outside the enabled set
      wr(3'd7, 8'h01);
      din[47:40] = ~din[47:40];
      cycles(4);
      chk("R6 irq for disabled group", {7'd0, irq}, 8'h00);
      rd(3'd7, d); chk("R6 status for disabled group", d, 8'h40);

      finish_run();
   end
endmodule